// File: doc/BRIEF.md
# CAM Match and Status Engine

This block holds a small content-addressable table of 16 entries. Each entry has a 64-bit key and a two-bit validity tag made of a Skip bit and an Empty bit. On a compare strobe, a 64-bit search key is checked against every entry in parallel under a per-bit exclude mask. The outcome is folded into a packed 32-bit status word with three flags: any match, more than one match and table full. All three flags are active low. The word also carries the address of the winning entry, which is the matching entry with the lowest address, and the validity tag of the entry read most recently.

There are two kinds of compare. An automatic compare looks only at valid entries, meaning Skip = 0 and Empty = 0. A forced compare looks at entries whose tag equals a selected pattern, which lets software find empty or skipped slots by content.

Entry writes and entry reads use valid/ready handshakes. A compare strobe takes priority over both. In a cycle where `cmp_go` is high, `wr_ready` and `rd_ready` are low, and an offered write or read waits until that cycle has passed. A read response arrives one clock after the read is accepted. The response has no back-pressure, so the consumer must take `rsp_valid` when it is high. The compare strobe and the status word are plain pins.

Top module: `cam_status_engine`

## Requirements
- R1: After reset the status word reads 32'hFFFF_FFFF and every entry holds key 0 with Skip = 0, Empty = 1.
- R2: A write is taken when `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly in cycles where `cmp_go` is high. A write offered in such a cycle changes no entry.
- R3: A read is taken when `rd_valid` and `rd_ready` are both high. `rd_ready` is low exactly in cycles where `cmp_go` is high. One clock after a read is taken, `rsp_valid` is high and `rsp_key` and `rsp_tag` hold the entry's contents. `rsp_tag` is {Skip, Empty}.
- R4: Status bits 29:28 equal {Skip, Empty} of the entry most recently read, from one clock after the read is taken. They read 2'b11 until the first read.
- R5: Status bit 31 is low exactly when no entry has Empty = 1. It follows a write one clock after that write is taken.
- R6: An entry's key matches when every key bit whose `cmp_mask` bit is 0 equals the corresponding bit of `cmp_key`. Key bits whose mask bit is 1 are ignored.
- R7: With `cmp_forced` = 0, only entries with Skip = 0 and Empty = 0 can match.
- R8: With `cmp_forced` = 1, only entries whose {Skip, Empty} equals `cmp_tag` can match. `cmp_tag[1]` is Skip and `cmp_tag[0]` is Empty.
- R9: Status bit 0 is low when at least one entry matched. Bits 27:1 then hold the lowest matching address, zero-extended. On no match, bit 0 is high and bits 27:1 are all ones.
- R10: Status bit 30 is low exactly when two or more entries matched.
- R11: Status bits 30, 27:1 and 0 take new values one clock after a cycle with `cmp_go` high, and hold their values in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_addr | input | 4 | Entry to write |
| wr_key | input | 64 | Key value to store |
| wr_tag | input | 2 | {Skip, Empty} to store |
| rd_valid | input | 1 | Read request offered |
| rd_ready | output | 1 | Read can be taken this cycle |
| rd_addr | input | 4 | Entry to read |
| rsp_valid | output | 1 | Read response present (no back-pressure) |
| rsp_key | output | 64 | Key of the entry read |
| rsp_tag | output | 2 | {Skip, Empty} of the entry read |
| cmp_go | input | 1 | Compare strobe |
| cmp_forced | input | 1 | 1 selects a forced compare |
| cmp_tag | input | 2 | Tag selected by a forced compare |
| cmp_key | input | 64 | Search key |
| cmp_mask | input | 64 | Exclude mask, 1 = bit ignored |
| status | output | 32 | Packed status word |

## Verification
The hardest situation to reach is a set of entries that sit in all four validity states and also share key bits. Only that mix separates a correct tag filter from one that ignores the tag, and a correct lowest-address pick from one that simply takes any hit. The stimulus gives the table keys that differ only in their low nibble, then rewrites the tags so that entry i carries tag i mod 4. It then sweeps every tag pattern, plus automatic mode, across every nibble value and several masks, so that single hits, multiple hits and no hits all occur under each filter. A write and a read offered together with a compare strobe check the back-pressure rule. Sequences of reads and writes between compares check that the match fields hold their values.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int STAT_W     = 32;
  localparam int ADDR_FLD_W = 27;

  typedef struct packed {
    logic skip;
    logic empty;
  } vtag_t;

  localparam vtag_t TAG_RESET = '{skip: 1'b0, empty: 1'b1};
  localparam vtag_t TAG_VALID = '{skip: 1'b0, empty: 1'b0};
endpackage

// File: rtl/cam_entry_store.sv
module cam_entry_store
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 64,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_fire,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [KEY_W-1:0]              wr_key,
  input  vtag_t                         wr_tag,
  input  logic                          rd_fire,
  input  logic [AW-1:0]                 rd_addr,
  output logic                          rsp_valid,
  output logic [KEY_W-1:0]              rsp_key,
  output vtag_t                         rsp_tag,
  output vtag_t                         last_tag,
  output logic [ENTRIES-1:0][KEY_W-1:0] keys,
  output vtag_t [ENTRIES-1:0]           tags,
  output logic                          any_empty
);
  logic [ENTRIES-1:0] empty_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        keys[g] <= '0;
        tags[g] <= TAG_RESET;
      end else if (wr_fire && wr_addr == AW'(g)) begin
        keys[g] <= wr_key;
        tags[g] <= wr_tag;
      end
    end
    assign empty_vec[g] = tags[g].empty;
  end

  assign any_empty = |empty_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_key   <= '0;
      rsp_tag   <= TAG_RESET;
      last_tag  <= 2'b11;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        rsp_key  <= keys[rd_addr];
        rsp_tag  <= tags[rd_addr];
        last_tag <= tags[rd_addr];
      end
    end
  end

  // R2
  wr_tag_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_fire) |-> tags[$past(wr_addr)] == $past(wr_tag));
  // R3
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_fire) && !($past(wr_fire) && $past(wr_addr) == $past(rd_addr))
      |-> rsp_key == keys[$past(rd_addr)]);
endmodule

// File: rtl/cam_match_vec.sv
module cam_match_vec
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 64
) (
  input  logic [ENTRIES-1:0][KEY_W-1:0] keys,
  input  vtag_t [ENTRIES-1:0]           tags,
  input  logic [KEY_W-1:0]              cmp_key,
  input  logic [KEY_W-1:0]              cmp_mask,
  input  logic                          cmp_forced,
  input  vtag_t                         cmp_tag,
  output logic [ENTRIES-1:0]            hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic key_eq;
    logic eligible;
    assign key_eq   = ~|((keys[g] ^ cmp_key) & ~cmp_mask);
    assign eligible = cmp_forced ? (tags[g] == cmp_tag) : (tags[g] == TAG_VALID);
    assign hit_vec[g] = key_eq && eligible;
  end
endmodule

// File: rtl/cam_prio_pick.sv
module cam_prio_pick #(
  parameter int ENTRIES = 16,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               any_hit,
  output logic               multi_hit,
  output logic [AW-1:0]      win_idx
);
  always_comb begin
    win_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = AW'(i);
    end
  end

  assign any_hit   = |hit_vec;
  assign multi_hit = |(hit_vec & (hit_vec - ENTRIES'(1)));

  // R9
  win_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> hit_vec[win_idx] && ((hit_vec & ((ENTRIES'(1) << win_idx) - ENTRIES'(1))) == '0));
  // R10
  multi_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi_hit == ($countones(hit_vec) > 1));
endmodule

// File: rtl/cam_status_engine.sv
module cam_status_engine
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int KEY_W   = 64,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [AW-1:0]    wr_addr,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [1:0]       wr_tag,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [AW-1:0]    rd_addr,
  output logic             rsp_valid,
  output logic [KEY_W-1:0] rsp_key,
  output logic [1:0]       rsp_tag,
  input  logic             cmp_go,
  input  logic             cmp_forced,
  input  logic [1:0]       cmp_tag,
  input  logic [KEY_W-1:0] cmp_key,
  input  logic [KEY_W-1:0] cmp_mask,
  output logic [31:0]      status
);
  logic                          wr_fire, rd_fire, any_empty;
  logic [ENTRIES-1:0][KEY_W-1:0] keys;
  vtag_t [ENTRIES-1:0]           tags;
  vtag_t                         rsp_tag_s, last_tag;
  logic [ENTRIES-1:0]            hit_vec;
  logic                          any_hit, multi_hit;
  logic [AW-1:0]                 win_idx;
  logic                          match_n_q, multi_n_q;
  logic [ADDR_FLD_W-1:0]         addr_q;

  assign wr_ready = !cmp_go;
  assign rd_ready = !cmp_go;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;

  cam_entry_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_key(wr_key), .wr_tag(vtag_t'(wr_tag)),
    .rd_fire(rd_fire), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_key(rsp_key), .rsp_tag(rsp_tag_s),
    .last_tag(last_tag), .keys(keys), .tags(tags), .any_empty(any_empty)
  );

  cam_match_vec #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) match_i (
    .keys(keys), .tags(tags), .cmp_key(cmp_key), .cmp_mask(cmp_mask),
    .cmp_forced(cmp_forced), .cmp_tag(vtag_t'(cmp_tag)), .hit_vec(hit_vec)
  );

  cam_prio_pick #(.ENTRIES(ENTRIES)) pick_i (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec),
    .any_hit(any_hit), .multi_hit(multi_hit), .win_idx(win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_n_q <= 1'b1;
      multi_n_q <= 1'b1;
      addr_q    <= '1;
    end else if (cmp_go) begin
      match_n_q <= !any_hit;
      multi_n_q <= !multi_hit;
      addr_q    <= any_hit ? {{(ADDR_FLD_W-AW){1'b0}}, win_idx} : '1;
    end
  end

  assign rsp_tag = rsp_tag_s;
  assign status  = {any_empty, multi_n_q, last_tag, addr_q, match_n_q};

  // R10
  multi_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status[30] |-> !status[0]);
  // R9
  nomatch_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> status[27:1] == '1);
  // R11
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmp_go) |-> $stable(status[30]) && $stable(status[27:0]));
  // R2
  no_write_on_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |-> !wr_fire && !rd_fire);
endmodule

// File: tb/cam_status_engine_tb.sv
module cam_status_engine_tb_top;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, rd_valid = 0, cmp_go = 0, cmp_forced = 0;
  logic wr_ready, rd_ready, rsp_valid;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [63:0] wr_key = 0, cmp_key = 0, cmp_mask = 0, rsp_key;
  logic [1:0] wr_tag = 0, cmp_tag = 0, rsp_tag;
  logic [31:0] status;
  int n_chk = 0, n_fail = 0;
  logic [63:0] m_key [N];
  logic [1:0]  m_tag [N];

  always #5 clk = ~clk;

  cam_status_engine dut_i (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [63:0] pat(input int i);
    return {48'h1234_5678_9ABC, 12'h0, 4'(i)};
  endfunction

  function automatic logic [31:0] exp_cmp(input logic [63:0] k, input logic [63:0] m,
                                          input logic f, input logic [1:0] t);
    int cnt = 0, first = -1;
    for (int i = 0; i < N; i++) begin
      logic elig = f ? (m_tag[i] == t) : (m_tag[i] == 2'b00);
      if (elig && (((m_key[i] ^ k) & ~m) == 0)) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    return {1'b0, cnt < 2, 2'b00, (cnt == 0) ? 27'h7FF_FFFF : 27'(first), cnt == 0};
  endfunction

  task automatic do_write(input int a, input logic [63:0] k, input logic [1:0] t);
    wr_valid = 1; wr_addr = 4'(a); wr_key = k; wr_tag = t;
    tick();
    wr_valid = 0;
    m_key[a] = k; m_tag[a] = t;
  endtask

  task automatic do_read(input int a, input string req);
    rd_valid = 1; rd_addr = 4'(a);
    tick();
    rd_valid = 0;
    check({req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    check({req, " rsp_key"}, rsp_key, m_key[a]);
    check({req, " rsp_tag"}, 64'(rsp_tag), 64'(m_tag[a]));
    check("R4 status[29:28]", 64'(status[29:28]), 64'(m_tag[a]));
  endtask

  task automatic do_cmp(input logic [63:0] k, input logic [63:0] m, input logic f,
                        input logic [1:0] t, input string req);
    cmp_go = 1; cmp_key = k; cmp_mask = m; cmp_forced = f; cmp_tag = t;
    tick();
    cmp_go = 0;
    check(req, 64'(status & 32'h4FFF_FFFF), 64'(exp_cmp(k, m, f, t)));
  endtask

  initial begin
    #(200000 * 10);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_key[i] = '0; m_tag[i] = 2'b01; end
    #22 rst_n = 1; #1;
    // R1 reset state
    check("R1 status", 64'(status), 64'hFFFF_FFFF);
    check("R2 wr_ready idle", 64'(wr_ready), 64'd1);
    do_cmp(64'd0, 64'd0, 1'b0, 2'b00, "R7 auto finds no empty entry");
    for (int i = 0; i < N; i++) do_read(i, "R1 R3 read after reset");
    do_cmp(64'd0, 64'd0, 1'b1, 2'b01, "R8 forced empty after reset");
    // R5 fill table, full flag falls only on last write
    for (int i = 0; i < N; i++) begin
      do_write(i, pat(i), 2'b00);
      check("R5 full flag", 64'(status[31]), 64'(i < N - 1));
    end
    // R6 R9 single exact hits
    for (int i = 0; i < N; i++) do_cmp(pat(i), 64'd0, 1'b0, 2'b00, "R6 R9 exact hit");
    // R10 duplicate key
    do_write(9, pat(3), 2'b00);
    do_cmp(pat(3), 64'd0, 1'b0, 2'b00, "R10 two hits");
    check("R10 multi low", 64'(status[30]), 64'd0);
    // R6 mask sweep
    for (int k = 0; k < N; k++) begin
      do_cmp(pat(k), 64'h1, 1'b0, 2'b00, "R6 mask bit0");
      do_cmp(pat(k), 64'h6, 1'b0, 2'b00, "R6 mask bits2:1");
      do_cmp(pat(k), 64'hF, 1'b0, 2'b00, "R6 mask nibble");
      do_cmp(pat(k) ^ 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 2'b00,
             "R6 masked top bit");
    end
    do_cmp(64'hDEAD_0000_0000_0000, 64'd0, 1'b0, 2'b00, "R9 no match");
    check("R9 addr all ones", 64'(status[27:1]), 64'h7FF_FFFF);
    // R7 R8 mixed tags: entry i tag = i mod 4
    for (int i = 0; i < N; i++) do_write(i, pat(i), 2'(i));
    check("R5 not full with empties", 64'(status[31]), 64'd1);
    for (int k = 0; k < N; k++) begin
      do_cmp(pat(k), 64'd0, 1'b0, 2'b00, "R7 auto mixed tags");
      do_cmp(pat(k), 64'h3, 1'b0, 2'b00, "R7 auto masked mixed");
      for (int t = 0; t < 4; t++) begin
        do_cmp(pat(k), 64'd0, 1'b1, 2'(t), "R8 forced exact");
        do_cmp(pat(k), 64'hC, 1'b1, 2'(t), "R8 forced masked");
      end
    end
    do_read(6, "R3 R4 skip entry");
    check("R4 skip bits 10", 64'(status[29:28]), 64'd2);
    // R11 hold across reads and writes
    do_cmp(pat(4), 64'hF, 1'b1, 2'b00, "R11 setup");
    begin
      logic [31:0] snap = status;
      do_write(0, 64'd0, 2'b10);
      do_read(3, "R3 read between compares");
      rd_valid = 0; tick();
      check("R11 hold", 64'(status & 32'h4FFF_FFFF), 64'(snap & 32'h4FFF_FFFF));
      check("R3 rsp_valid drops", 64'(rsp_valid), 64'd0);
    end
    // R2 R3 back-pressure while compare
    wr_valid = 1; wr_addr = 4'd5; wr_key = 64'hBAD; wr_tag = 2'b00;
    rd_valid = 1; rd_addr = 4'd7;
    cmp_go = 1; cmp_key = 64'd0; cmp_mask = '1; cmp_forced = 1; cmp_tag = 2'b11;
    #1;
    check("R2 wr_ready low on compare", 64'(wr_ready), 64'd0);
    check("R3 rd_ready low on compare", 64'(rd_ready), 64'd0);
    tick();
    cmp_go = 0; wr_valid = 0; rd_valid = 0;
    check("R3 no response when refused", 64'(rsp_valid), 64'd0);
    check("R8 forced tag 11 all-masked", 64'(status & 32'h4FFF_FFFF),
          64'(exp_cmp(64'd0, '1, 1'b1, 2'b11)));
    do_read(5, "R2 refused write left entry");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule